// File: doc/BRIEF.md
# Power and Clock Control Unit

This block holds an 11-bit control word. The word sets the power state and the clock routing of a receiver's clocking section. Software loads the whole word with a single write strobe and reads it back on a parallel port. The block decodes the word into a set of enables and selectors:

- RF front-end power-down
- differential clock input enable
- PLL enable and PLL reset
- system clock gate
- crystal oscillator enable
- PLL reference select
- PLL bypass select

The analog parts (PLL, oscillator, pads) are not modelled here. They appear only as these control levels.

Two parts of the control word act over time. First, a cleared PLL power-down bit takes effect only after a fixed number of pulses of a slow real-time strobe. Setting the bit acts at once. Second, the three sleep bits clear themselves when a wake-up pulse arrives. The block also contains the programmable output divider. The divider counts input clock-enable pulses and emits one strobe every 1, 2, 4 or 8 of them.

Top module: `pwr_clk_ctl`

## Requirements
- R1: After reset the read-back word is 0x036. In that word, bit 10 is RF sleep, bit 9 is PLL sleep, bit 8 is system-clock sleep, bits 7:6 are divider select, bit 5 is bypass, bits 4:3 are reference select, bit 2 is PLL power-down, bit 1 is oscillator enable and bit 0 is RF power-down.
- R2: A cycle with `wr_en` high loads all 11 bits of `wr_data`. The new word is visible on `rd_data` after that clock edge.
- R3: The divider select field sets the ratio N: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. `div_stb` is high, in the same cycle, on every N-th cycle that has `src_en` high, and never without `src_en`.
- R4: A write that changes the divider select restarts the count. The first strobe then comes on the N-th `src_en` after that write.
- R5: Writing 1 to PLL power-down drops `pll_en` in the cycle after the write.
- R6: After a write moves PLL power-down from 1 to 0, `pll_en` rises in the cycle after the 6th `slow_tick` pulse. The count starts in the cycle after the write. A pulse in the write cycle itself is not counted.
- R7: Setting PLL power-down again during the count cancels the count. The next 1-to-0 change restarts the count from zero.
- R8: A `wake_evt` pulse clears bits 10:8. When a write falls in the same cycle, the clear wins over the written sleep bits, and the other written bits still load.
- R9: While PLL sleep is set, `pll_rst` is high and `pll_en` is low.
- R10: While RF sleep or RF power-down is set, `diff_in_en` is low. In the same condition, `rf_pd_pin` is high if `io_cfg_en` is high. `rf_pd_pin` is low in every other case.
- R11: `bypass` follows bit 5, `ref_sel` follows bits 4:3 (0x selects the crystal, 10 selects master/2, 11 selects master/4), `xtal_en` follows bit 1, and `sysclk_en` is the inverse of bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_data | input | 11 | word to load |
| rd_data | output | 11 | current control word |
| wake_evt | input | 1 | one-cycle wake-up pulse |
| slow_tick | input | 1 | one-cycle real-time strobe |
| src_en | input | 1 | divider input clock enable |
| io_cfg_en | input | 1 | lets the RF power-down level reach the pin |
| div_stb | output | 1 | divided clock-enable strobe |
| pll_en | output | 1 | PLL enable |
| pll_rst | output | 1 | PLL reset |
| diff_in_en | output | 1 | differential input enable |
| rf_pd_pin | output | 1 | RF power-down, active high |
| sysclk_en | output | 1 | system clock gate enable |
| xtal_en | output | 1 | crystal oscillator enable |
| ref_sel | output | 2 | PLL reference select |
| bypass | output | 1 | PLL bypass select |

## Verification
A wrong delay counter shows as `pll_en` rising one or more slow ticks too early or too late. It can also show as a rise after a cancelled count. It is visible within the ticks of one power-up sequence. A stale divider count shows up at the first strobe after a ratio change, as a short or long period. A stuck sleep or configuration bit shows on `rd_data` and on the decoded outputs one cycle after the write or wake-up pulse that should have changed it.

// File: rtl/pwr_clk_ctl.sv
module pwr_clk_ctl #(
  parameter int DLY_TICKS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [10:0] wr_data,
  output logic [10:0] rd_data,
  input  logic        wake_evt,
  input  logic        slow_tick,
  input  logic        src_en,
  input  logic        io_cfg_en,
  output logic        div_stb,
  output logic        pll_en,
  output logic        pll_rst,
  output logic        diff_in_en,
  output logic        rf_pd_pin,
  output logic        sysclk_en,
  output logic        xtal_en,
  output logic [1:0]  ref_sel,
  output logic        bypass
);
  localparam logic [10:0] RST_WORD = 11'h036;
  localparam int TCW = $clog2(DLY_TICKS + 1);

  logic [10:0]    ctl;
  logic           pd_eff, busy;
  logic [TCW-1:0] tcnt;
  logic [2:0]     dcnt, dlim;
  logic           rf_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= RST_WORD;
    else begin
      if (wr_en) ctl <= wr_data;
      if (wake_evt) ctl[10:8] <= 3'b000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_eff <= 1'b1;
      busy   <= 1'b0;
      tcnt   <= '0;
    end else if (wr_en && wr_data[2]) begin
      pd_eff <= 1'b1;
      busy   <= 1'b0;
    end else if (wr_en && !wr_data[2] && ctl[2]) begin
      busy <= 1'b1;
      tcnt <= '0;
    end else if (busy && slow_tick) begin
      if (tcnt == TCW'(DLY_TICKS - 1)) begin
        pd_eff <= 1'b0;
        busy   <= 1'b0;
      end else tcnt <= tcnt + 1'b1;
    end
  end

  assign dlim = 3'((4'd1 << ctl[7:6]) - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (wr_en && wr_data[7:6] != ctl[7:6]) dcnt <= '0;
    else if (src_en) dcnt <= (dcnt == dlim) ? 3'd0 : dcnt + 3'd1;
  end

  assign rf_off     = ctl[10] | ctl[0];
  assign rd_data    = ctl;
  assign div_stb    = src_en && (dcnt == dlim);
  assign pll_en     = !pd_eff && !ctl[9];
  assign pll_rst    = ctl[9];
  assign diff_in_en = !rf_off;
  assign rf_pd_pin  = io_cfg_en && rf_off;
  assign sysclk_en  = !ctl[8];
  assign xtal_en    = ctl[1];
  assign ref_sel    = ctl[4:3];
  assign bypass     = ctl[5];

  AST_PD_SET_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[2] |=> !pll_en); // R5
  AST_EN_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_eff && $past(pd_eff) |-> $past(slow_tick) && $past(busy)); // R6
  AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[2] |=> !busy); // R7
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> rd_data[10:8] == 3'b000); // R8
  AST_SLEEP_RST: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> !pll_en); // R9
  AST_STB_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    div_stb |-> src_en); // R3
  AST_RATIO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[7:6] != rd_data[7:6] && wr_data[7:6] != 2'b00 |=> !div_stb); // R4
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !io_cfg_en |-> !rf_pd_pin); // R10
endmodule

// File: tb/pwr_clk_ctl_tb_top.sv
module pwr_clk_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wake_evt = 0, slow_tick = 0, src_en = 0, io_cfg_en = 0;
  logic [10:0] wr_data = '0;
  logic [10:0] rd_data;
  logic div_stb, pll_en, pll_rst, diff_in_en, rf_pd_pin, sysclk_en, xtal_en, bypass;
  logic [1:0] ref_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [10:0] m_reg;
  logic m_pde, m_busy;
  int m_tcnt, m_dcnt;

  always #5 clk = ~clk;

  pwr_clk_ctl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wake_evt(wake_evt), .slow_tick(slow_tick), .src_en(src_en),
    .io_cfg_en(io_cfg_en), .div_stb(div_stb), .pll_en(pll_en), .pll_rst(pll_rst),
    .diff_in_en(diff_in_en), .rf_pd_pin(rf_pd_pin), .sysclk_en(sysclk_en),
    .xtal_en(xtal_en), .ref_sel(ref_sel), .bypass(bypass));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ratio(input logic [1:0] s);
    return 1 << s;
  endfunction

  task automatic model_reset();
    m_reg = 11'h036; m_pde = 1; m_busy = 0; m_tcnt = 0; m_dcnt = 0;
  endtask

  task automatic step(input logic w, input logic [10:0] d, input logic wk,
                      input logic tk, input logic sc, input logic io);
    logic sl;
    logic [10:0] nreg;
    @(negedge clk);
    wr_en = w; wr_data = d; wake_evt = wk; slow_tick = tk; src_en = sc; io_cfg_en = io;
    #1;
    sl = m_reg[10] | m_reg[0];
    chk(rd_data == m_reg, "R2 rd_data", rd_data, m_reg);
    chk(div_stb == (sc && m_dcnt == ratio(m_reg[7:6]) - 1), "R3 div_stb", div_stb,
        sc && m_dcnt == ratio(m_reg[7:6]) - 1);
    chk(pll_en == (!m_pde && !m_reg[9]), "R6 pll_en", pll_en, !m_pde && !m_reg[9]);
    chk(pll_rst == m_reg[9], "R9 pll_rst", pll_rst, m_reg[9]);
    chk(diff_in_en == !sl, "R10 diff_in_en", diff_in_en, !sl);
    chk(rf_pd_pin == (io && sl), "R10 rf_pd_pin", rf_pd_pin, io && sl);
    chk({bypass, ref_sel, xtal_en, sysclk_en} == {m_reg[5], m_reg[4:3], m_reg[1], !m_reg[8]},
        "R11 decode", {bypass, ref_sel, xtal_en, sysclk_en},
        {m_reg[5], m_reg[4:3], m_reg[1], !m_reg[8]});
    nreg = w ? d : m_reg;
    if (wk) nreg[10:8] = 3'b000;
    if (w && d[2]) begin m_pde = 1; m_busy = 0; end
    else if (w && !d[2] && m_reg[2]) begin m_busy = 1; m_tcnt = 0; end
    else if (m_busy && tk) begin
      if (m_tcnt == 5) begin m_pde = 0; m_busy = 0; end
      else m_tcnt++;
    end
    if (w && d[7:6] != m_reg[7:6]) m_dcnt = 0;
    else if (sc) m_dcnt = (m_dcnt == ratio(m_reg[7:6]) - 1) ? 0 : m_dcnt + 1;
    m_reg = nreg;
  endtask

  task automatic idle(input logic tk);
    step(0, 11'h0, 0, tk, 0, 1);
  endtask

  task automatic post_chk_pll(input logic exp, input string req);
    @(posedge clk); #1;
    chk(pll_en == exp, req, pll_en, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7531));
    model_reset();
    #22;
    chk(rd_data == 11'h036, "R1 reset word", rd_data, 11'h036);
    chk(pll_en == 0 && pll_rst == 0, "R1 pll off at reset", pll_en, 0);
    @(negedge clk); rst_n = 1;

    // R6: clear power-down, tick in write cycle ignored, then 6 ticks
    step(1, 11'h032, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) idle(1);
    post_chk_pll(0, "R6 still off after 5 ticks");
    idle(1);
    post_chk_pll(1, "R6 on after 6th tick");
    // R5 immediate disable
    step(1, 11'h036, 0, 0, 0, 1);
    post_chk_pll(0, "R5 set disables next cycle");
    // R7 cancel and restart
    step(1, 11'h032, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) idle(1);
    step(1, 11'h036, 0, 0, 0, 1);
    step(1, 11'h032, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) idle(1);
    post_chk_pll(0, "R7 restart not early");
    idle(1);
    post_chk_pll(1, "R7 on after full restart");
    // R9 PLL sleep
    step(1, 11'h232, 0, 0, 0, 1);
    @(posedge clk); #1;
    chk(pll_rst == 1 && pll_en == 0, "R9 sleep resets pll", {pll_rst, pll_en}, 2'b10);
    // R8 wake wins over write of sleep bits
    step(1, 11'h7F2, 1, 0, 0, 1);
    @(posedge clk); #1;
    chk(rd_data == 11'h0F2, "R8 wake priority", rd_data, 11'h0F2);
    // R4 ratio change restart: ratio 8 -> count some, change to 4
    step(1, 11'h1F2 & 11'h0F2, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1);
    step(1, 11'h0B2, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0);
    @(negedge clk); src_en = 1; #1;
    chk(div_stb == 1, "R4 first strobe on 4th enable", div_stb, 1);
    // R10 rf power-down with io gate
    step(1, 11'h033, 0, 0, 0, 0);
    @(negedge clk); io_cfg_en = 0; #1;
    chk(rf_pd_pin == 0 && diff_in_en == 0, "R10 pin gated", rf_pd_pin, 0);
    io_cfg_en = 1; #1;
    chk(rf_pd_pin == 1, "R10 pin driven", rf_pd_pin, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [10:0] d;
      d = 11'($urandom);
      if ($urandom_range(3) != 0) d[10:8] = 3'b000;
      step($urandom_range(7) == 0, d, $urandom_range(15) == 0,
           $urandom_range(3) == 0, $urandom_range(1) == 1, 1'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule